// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of an Ethernet MAC's DMA path. It takes frames as a byte stream and walks a ring of two-word descriptors in shared memory. For each buffer it fills, it stores the frame bytes and then writes the status word. Last, it marks the descriptor as filled, so software can see it. The ring starts at a programmable base address. Software returns a buffer to the engine by clearing its ownership bit.

Frames longer than one buffer run on into the following descriptors. The first descriptor of a frame carries a start flag, the last carries an end flag and the total length. The four-byte FCS can be left out of both the stored data and the length. If a frame arrives while the ring is still full, the frame is dropped and a one-cycle overrun pulse is raised.

Top module: `rx_desc_ring`

## Requirements
- R1: Descriptor word 0 holds the buffer address in bits 31:2 and a wrap marker in bit 1. After a descriptor with the wrap marker, the next descriptor is read at the ring base; otherwise it is read 8 bytes further on.
- R2: Stored frame bytes go into the buffer in arrival order, packed little-endian: byte n of a buffer lands in word n/4, lane n%4.
- R3: Word 1 (descriptor address + 4) is written back with these fields:
  - bits 13:0 hold the total stored frame length in the last descriptor of the frame and 0 in the others;
  - bit 14 is set only in the first descriptor;
  - bit 15 is set only in the last descriptor;
  - bit 16 is set in the last descriptor when the end-of-frame byte carried the error marker.
- R4: At writeback, word 0 is rewritten with bit 0 set and its address and wrap bits unchanged. Word 1 is written in the cycle just before word 0.
- R5: A buffer holds BUF_UNITS×64 bytes (1536 by default). A longer frame continues into the next descriptor. A frame that ends exactly at a buffer boundary uses no extra descriptor.
- R6: With FCS stripping on, the final 4 bytes of a frame are neither stored nor counted. A frame of 4 bytes or fewer yields one descriptor with start and end set and length 0.
- R7: If a fetched word 0 already has bit 0 set, the rest of the frame is consumed and discarded. The engine then pulses the overrun output for exactly one cycle and stays on that descriptor.
- R8: A frame whose start byte arrives while receive is disabled is consumed with no memory access. While receive is disabled and no frame is in progress, the ring position follows the base input.
- R9: After reset the engine is idle, with no memory request, no overrun pulse and the input ready.
- R10: The input ready is low in two cases: while a start byte waits for its descriptor to be read and checked, and while a full buffer must be written back before the next byte can be stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable, sampled at frame start |
| cfg_fcs_strip | input | 1 | Drop the trailing 4 FCS bytes |
| cfg_ring_base | input | 32 | Byte address of descriptor 0, 8-byte aligned |
| in_valid | input | 1 | Byte present on the stream |
| in_rdy | output | 1 | Engine accepts the byte this cycle |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Frame error marker, qualified by in_eof |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ovr_pulse | output | 1 | One-cycle pulse when a frame is dropped for lack of a free descriptor |

## Verification
A wrong ring position shows up at the next writeback: a frame lands in the wrong descriptor, or skips the base after a wrap. The bench sees this as soon as it reads the ring after that frame. A stale byte counter or hold-line state corrupts the length in word 1 or shifts the buffer bytes. Frames that end on a buffer boundary, and short frames with FCS stripping on, expose these errors within one frame. An ownership slip shows in two ways: a descriptor owned by software gets overwritten, or a frame is dropped while the overrun output stays low. The bench checks the first case against a preloaded filled descriptor.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_CHECK = 3'd2,
        S_DATA  = 3'd3,
        S_FLUSH = 3'd4,
        S_WB1   = 3'd5,
        S_WB0   = 3'd6,
        S_DROP  = 3'd7
    } rxr_st_e;

    localparam int LEN_W   = 14;
    localparam int SOF_BIT = 14;
    localparam int EOF_BIT = 15;
    localparam int ERR_BIT = 16;
endpackage

// File: rtl/rxr_fcs_hold.sv
`timescale 1ns/1ps
// Holding line that delays stored bytes by the FCS length when stripping.
module rxr_fcs_hold #(
    parameter int FCS_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic       strip,
    input  logic [7:0] din,
    output logic       will_emit,
    output logic [7:0] dout
);
    localparam int LW = 8 * FCS_BYTES;
    localparam int FW = $clog2(FCS_BYTES + 1);

    typedef struct packed {
        logic [LW-1:0] line;
        logic [FW-1:0] fill;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        will_emit = !strip || (h_q.fill == FW'(FCS_BYTES));
        dout      = strip ? h_q.line[7:0] : din;
        if (clear) begin
            h_d.fill = '0;
        end else if (push && strip) begin
            h_d.line = {din, h_q.line[LW-1:8]};
            if (h_q.fill != FW'(FCS_BYTES))
                h_d.fill = h_q.fill + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/rxr_ring_next.sv
`timescale 1ns/1ps
// Next descriptor position: back to base after a wrap marker, else one stride on.
module rxr_ring_next #(
    parameter int AW     = 32,
    parameter int STRIDE = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          wrap,
    output logic [AW-1:0] nxt
);
    always_comb nxt = wrap ? base : cur + AW'(STRIDE);
endmodule

// File: rtl/rx_desc_ring.sv
`timescale 1ns/1ps
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter int BUF_UNITS = 8'h18,
    parameter int FCS_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rx_en,
    input  logic        cfg_fcs_strip,
    input  logic [31:0] cfg_ring_base,
    input  logic        in_valid,
    output logic        in_rdy,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_err,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        ovr_pulse
);
    localparam int BUF_BYTES = BUF_UNITS * 64;
    localparam int CW        = $clog2(BUF_BYTES + 1);

    typedef struct packed {
        rxr_st_e          st;
        logic [31:0]      ptr;
        logic [31:0]      desc;
        logic [CW-1:0]    cnt;
        logic [LEN_W-1:0] tot;
        logic [31:0]      word;
        logic             first;
        logic             done;
        logic             err;
        logic             ovr;
    } regs_t;

    regs_t       r_d, r_q;
    rxr_st_e     st_q;
    logic        push, will_emit, full;
    logic [7:0]  hold_byte;
    logic [31:0] ring_nxt, buf_base, word_off, merged, w1;

    rxr_fcs_hold #(.FCS_BYTES(FCS_BYTES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_q.st == S_IDLE),
        .push     (push),
        .strip    (cfg_fcs_strip),
        .din      (in_data),
        .will_emit(will_emit),
        .dout     (hold_byte)
    );

    rxr_ring_next #(.AW(32), .STRIDE(8)) u_next (
        .cur (r_q.ptr),
        .base(cfg_ring_base),
        .wrap(r_q.desc[1]),
        .nxt (ring_nxt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ovr   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ptr;
        mem_wdata = '0;
        in_rdy    = 1'b0;
        push      = 1'b0;
        full      = (r_q.cnt == CW'(BUF_BYTES));
        buf_base  = {r_q.desc[31:2], 2'b00};
        word_off  = {{(32-CW){1'b0}}, r_q.cnt[CW-1:2], 2'b00};
        merged    = r_q.word | ({24'b0, hold_byte} << {r_q.cnt[1:0], 3'b000});
        w1        = '0;
        w1[LEN_W-1:0] = r_q.done ? r_q.tot : '0;
        w1[SOF_BIT]   = r_q.first;
        w1[EOF_BIT]   = r_q.done;
        w1[ERR_BIT]   = r_q.done && r_q.err;

        case (r_q.st)
            S_IDLE: begin
                in_rdy = !(cfg_rx_en && in_sof);
                if (!cfg_rx_en) r_d.ptr = cfg_ring_base;
                if (in_valid) begin
                    if (cfg_rx_en && in_sof) begin
                        r_d.st    = S_FETCH;
                        r_d.first = 1'b1;
                        r_d.tot   = '0;
                        r_d.done  = 1'b0;
                        r_d.err   = 1'b0;
                    end else if (in_sof && !in_eof) begin
                        r_d.st = S_DROP;
                    end
                end
            end
            S_FETCH: begin
                mem_req = 1'b1;
                r_d.st  = S_CHECK;
            end
            S_CHECK: begin
                if (mem_rdata[0]) begin
                    r_d.ovr = 1'b1;
                    r_d.st  = S_DROP;
                end else begin
                    r_d.desc = mem_rdata;
                    r_d.cnt  = '0;
                    r_d.word = '0;
                    r_d.st   = S_DATA;
                end
            end
            S_DATA: begin
                in_rdy = !(full && will_emit);
                push   = in_valid && in_rdy;
                if (push) begin
                    if (will_emit) begin
                        r_d.cnt  = r_q.cnt + CW'(1);
                        r_d.tot  = r_q.tot + LEN_W'(1);
                        r_d.word = merged;
                        if (r_q.cnt[1:0] == 2'd3) begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = buf_base + word_off;
                            mem_wdata = merged;
                            r_d.word  = '0;
                        end
                    end
                    if (in_eof) begin
                        r_d.done = 1'b1;
                        r_d.err  = in_err;
                        r_d.st   = (r_d.cnt[1:0] != 2'd0) ? S_FLUSH : S_WB1;
                    end
                end else if (in_valid) begin
                    r_d.st = S_WB1;
                end
            end
            S_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_base + word_off;
                mem_wdata = r_q.word;
                r_d.word  = '0;
                r_d.st    = S_WB1;
            end
            S_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.ptr + 32'd4;
                mem_wdata = w1;
                r_d.st    = S_WB0;
            end
            S_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.desc | 32'd1;
                r_d.ptr   = ring_nxt;
                r_d.first = 1'b0;
                r_d.cnt   = '0;
                r_d.st    = r_q.done ? S_IDLE : S_FETCH;
            end
            S_DROP: begin
                in_rdy = 1'b1;
                if (in_valid && in_eof) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ovr_pulse = r_q.ovr;
    assign st_q      = r_q.st;
endmodule

// File: rtl/rxr_chk.sv
`timescale 1ns/1ps
module rxr_chk
    import rxr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input rxr_st_e     st,
    input logic        in_rdy,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        ovr_pulse
);
    AST_LEN_BEFORE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WB1) |=> (st == S_WB0 && mem_req && mem_we && mem_addr == $past(mem_addr) - 32'd4)); // R4

    AST_OVR_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(mem_req && !mem_we, 2)); // R7

    AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |=> !ovr_pulse); // R7

    AST_NO_ACCEPT_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !in_rdy); // R10

    AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req); // R1

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
endmodule

bind rx_desc_ring rxr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .in_rdy   (in_rdy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .ovr_pulse(ovr_pulse)
);

// File: tb/rx_desc_ring_tb.sv
`timescale 1ns/1ps
module rx_desc_ring_tb;
    localparam int BUFB = 64;
    localparam int NV   = 6;
    // stimulus: frame length, FCS strip, error marker; expected: descriptors used
    localparam int VLEN  [NV] = '{10, 64, 70, 68, 3, 130};
    localparam bit VSTR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam bit VERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam int VNBUF [NV] = '{1, 1, 2, 1, 1, 3};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_rx_en = 1'b0, cfg_fcs_strip = 1'b0;
    logic [31:0] cfg_ring_base = 32'h100;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_rdy, mem_req, mem_we, ovr_pulse;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_wdata = '0;
    logic [31:0] mem [1024];
    int nchk = 0, nerr = 0, nreq = 0, novr = 0;
    int cur = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_desc_ring #(.BUF_UNITS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_fcs_strip(cfg_fcs_strip),
        .cfg_ring_base(cfg_ring_base), .in_valid(in_valid), .in_rdy(in_rdy),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ovr_pulse(ovr_pulse)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else if (tb_we)        mem[tb_addr[11:2]]  <= tb_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
        if (mem_req)   nreq <= nreq + 1;
        if (ovr_pulse) novr <= novr + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bwrite(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_wdata = d;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic send_frame(input int len, input int seed, input bit err);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(seed + j);
            in_sof = (j == 0); in_eof = (j == len - 1); in_err = err && (j == len - 1);
            #1;
            while (!in_rdy) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic check_frame(input int rbase, input int bbase, input int rn, input int start,
                               input int len, input bit strip, input bit err, input int nbuf,
                               input int seed);
        int stored, idx, nb, bad;
        logic [31:0] e0, e1, ba, w;
        stored = strip ? ((len > 4) ? len - 4 : 0) : len;
        for (int k = 0; k < nbuf; k++) begin
            idx = (start + k) % rn;
            ba  = 32'(bbase + idx * BUFB);
            e0  = ba | ((idx == rn - 1) ? 32'd2 : 32'd0) | 32'd1;
            e1  = ((k == nbuf - 1) && err ? 32'h10000 : 32'd0)
                | ((k == nbuf - 1) ? (32'h8000 | 32'(stored)) : 32'd0)
                | ((k == 0) ? 32'h4000 : 32'd0);
            w = mem[(rbase + 8 * idx + 4) >> 2];
            chk(w == e1, "R3", "status word flags/length", w, e1);
            w = mem[(rbase + 8 * idx) >> 2];
            chk(w == e0, "R4", "owner bit and address word", w, e0);
            nb  = (k == nbuf - 1) ? stored - BUFB * k : BUFB;
            bad = 0;
            for (int j = 0; j < nb; j++) begin
                w = mem[(ba + 32'(j)) >> 2] >> (8 * (j % 4));
                if (w[7:0] != 8'(seed + BUFB * k + j)) bad++;
            end
            chk(bad == 0, "R2", "buffer bytes mismatching (R5 spanning)", 32'(bad), 32'd0);
            bwrite(32'(rbase + 8 * idx), e0 & ~32'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int ovr0, req0;
        logic [31:0] keep1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R9: reset state
        chk(in_rdy == 1'b1, "R9", "in_rdy after reset", 32'(in_rdy), 32'd1);
        chk(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 32'd0);
        chk(ovr_pulse == 1'b0, "R9", "ovr after reset", 32'(ovr_pulse), 32'd0);

        for (int i = 0; i < 4; i++) begin
            bwrite(32'h100 + 32'(8 * i), 32'h400 + 32'(64 * i) | ((i == 3) ? 32'd2 : 32'd0));
            bwrite(32'h104 + 32'(8 * i), 32'd0);
        end
        for (int i = 0; i < 2; i++) begin
            bwrite(32'h200 + 32'(8 * i), 32'h600 + 32'(64 * i) | ((i == 1) ? 32'd2 : 32'd0));
            bwrite(32'h204 + 32'(8 * i), 32'd0);
        end
        @(negedge clk); cfg_rx_en = 1'b1;
        @(negedge clk);

        // R10: start byte waits for its descriptor
        in_valid = 1'b1; in_sof = 1'b1; #1;
        chk(in_rdy == 1'b0, "R10", "in_rdy with pending start", 32'(in_rdy), 32'd0);
        in_valid = 1'b0; in_sof = 1'b0;

        // R1 R2 R3 R5 R6: vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk); cfg_fcs_strip = VSTR[v];
            send_frame(VLEN[v], 16 * v + 1, VERR[v]);
            check_frame(32'h100, 32'h400, 4, cur, VLEN[v], VSTR[v], VERR[v], VNBUF[v], 16 * v + 1);
            cur = (cur + VNBUF[v]) % 4;
        end
        chk(novr == 0, "R7", "no overrun during table", 32'(novr), 32'd0);

        // R7: overrun on descriptor still filled
        @(negedge clk); cfg_fcs_strip = 1'b0;
        bwrite(32'h100 + 32'(8 * cur), 32'h400 + 32'(64 * cur) | 32'd1);
        keep1 = mem[(32'h104 + 32'(8 * cur)) >> 2];
        ovr0 = novr;
        send_frame(10, 200, 1'b0);
        chk(novr == ovr0 + 1, "R7", "overrun pulses", 32'(novr - ovr0), 32'd1);
        chk(mem[(32'h104 + 32'(8 * cur)) >> 2] == keep1, "R7", "filled desc untouched",
            mem[(32'h104 + 32'(8 * cur)) >> 2], keep1);
        bwrite(32'h100 + 32'(8 * cur), 32'h400 + 32'(64 * cur));
        send_frame(12, 90, 1'b0);
        check_frame(32'h100, 32'h400, 4, cur, 12, 1'b0, 1'b0, 1, 90); // R7 same slot reused
        cur = (cur + 1) % 4;

        // R8: disabled frame consumed without memory access
        @(negedge clk); cfg_rx_en = 1'b0;
        req0 = nreq;
        send_frame(8, 40, 1'b0);
        chk(nreq == req0, "R8", "memory accesses while disabled", 32'(nreq - req0), 32'd0);

        // R8 R1: ring position follows base while disabled, then wraps to it
        @(negedge clk); cfg_ring_base = 32'h200;
        repeat (2) @(negedge clk);
        cfg_rx_en = 1'b1;
        send_frame(70, 120, 1'b0);
        check_frame(32'h200, 32'h600, 2, 0, 70, 1'b0, 1'b0, 2, 120);
        send_frame(5, 7, 1'b0);
        check_frame(32'h200, 32'h600, 2, 0, 5, 1'b0, 1'b0, 1, 7); // R1 wrap to base

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule